// File: doc/BRIEF.md
# Victim Buffer for a Direct-Mapped Cache

This block is a small, fully associative store placed between a direct-mapped cache and the next memory level. It holds whole lines that the direct-mapped array has recently pushed out. When the primary controller misses, it presents the missing block address together with the line that the miss would displace from its set. The buffer searches every entry by full block address and reports the outcome one cycle later.

On a victim hit, the buffer returns the stored line and its dirty bit. In the same step the displaced line takes over the freed entry, so the two lines trade places. Two blocks that keep colliding in one set therefore bounce between the array and the buffer, and the next level never sees them. On a victim miss, the displaced line is filed into a free entry. If no entry is free, it replaces the entry that was written longest ago. That old entry is written back first when it is dirty. The probed block is then requested from the next level, and its data is handed to the primary controller. Because the probe runs before the next-level request, every full miss pays the one lookup cycle.

The control is a six-state machine. `S_IDLE` accepts a probe and moves to `S_LOOK`. `S_LOOK` reports hit or miss. On a hit it returns to `S_IDLE`. On a miss it goes to `S_WBACK` when a dirty entry must be discarded, and otherwise to `S_FETCH`. `S_WBACK` moves to `S_FETCH` once the write-back is accepted. `S_FETCH` moves to `S_WAIT` once the request is accepted. `S_WAIT` moves to `S_FILL` when the response arrives. `S_FILL` presents the line for one cycle and returns to `S_IDLE`.

Top module: `victim_buffer`

## Requirements
- R1: After reset the buffer is empty, `prb_ready` is 1, and `lk_done`, `fill_valid`, `mem_req_valid` and `wb_valid` are 0. A first probe of any address misses.
- R2: A probe is accepted when `prb_valid` and `prb_ready` are both 1. `lk_done` is 1 in exactly the following cycle, and `prb_ready` stays 0 until the transaction is over.
- R3: With `lk_done` high, `lk_hit` is 1 exactly when a valid entry holds the probed block address. On a hit, `lk_data` and `lk_dirty` carry that entry's line and dirty bit.
- R4: On a hit, the displaced line (`dsp_valid`=1) takes the hit entry, and the hit block is no longer held. A later probe of the displaced address hits, and a later probe of the returned address misses. A hit causes no next-level request and no write-back, and `prb_ready` is 1 again in the cycle after `lk_done`.
- R5: On a miss, `mem_req_valid` is raised with `mem_req_addr` equal to the probed address, after any write-back. The cycle after `mem_rsp_valid` is seen in the wait state, `fill_valid` is 1 for one cycle and `fill_data` equals `mem_rsp_data`.
- R6: On a miss with a displaced line and a free entry, the line is stored and no write-back is issued.
- R7: On a miss with a displaced line and all entries full, the entry that was written longest ago (by insert or by hit-swap) is discarded. If it is dirty, `wb_valid` presents its address and data before the next-level request.
- R8: A clean discarded entry is dropped with no write-back.
- R9: On a hit with `dsp_valid`=0, the hit entry is freed and nothing takes its place.
- R10: Two block addresses that alternate as probe and displaced line hit on every alternation after both have been seen once, with no next-level traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prb_valid | input | 1 | Probe request from the primary controller |
| prb_ready | output | 1 | Buffer idle and able to take a probe |
| prb_addr | input | AW | Block address that missed in the primary array |
| dsp_valid | input | 1 | A line is being displaced from the primary set |
| dsp_addr | input | AW | Block address of the displaced line |
| dsp_dirty | input | 1 | Displaced line is modified |
| dsp_data | input | DW | Displaced line data |
| lk_done | output | 1 | Lookup result valid |
| lk_hit | output | 1 | Probed block found in the buffer |
| lk_data | output | DW | Line returned on a hit |
| lk_dirty | output | 1 | Dirty bit of the returned line |
| fill_valid | output | 1 | Line from the next level ready for the primary array |
| fill_data | output | DW | Line fetched from the next level |
| mem_req_valid | output | 1 | Read request to the next level |
| mem_req_ready | input | 1 | Next level accepts the read request |
| mem_req_addr | output | AW | Block address requested |
| mem_rsp_valid | input | 1 | Next-level read data valid |
| mem_rsp_data | input | DW | Next-level read data |
| wb_valid | output | 1 | Write-back of a discarded dirty line |
| wb_ready | input | 1 | Next level accepts the write-back |
| wb_addr | output | AW | Address of the written-back line |
| wb_data | output | DW | Data of the written-back line |

## Verification
The main pattern is a pair of conflicting blocks that alternate as probe and displaced line. Its hits show that the swap happens and that no next-level traffic follows. Probes with no displaced line show whether a hit entry is really freed rather than kept. A run of fresh blocks with mixed dirty bits fills the buffer past capacity. That run separates discarding the oldest entry from discarding any other one, and a dirty discard (write-back before fetch) from a clean one (no write-back). A queue-based recency model in the bench predicts every hit, returned line and write-back.

// File: rtl/vb_pkg.sv
package vb_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOOK,
        S_WBACK,
        S_FETCH,
        S_WAIT,
        S_FILL
    } vb_state_e;
endpackage

// File: rtl/vb_match.sv
module vb_match #(
    parameter int N  = 4,
    parameter int AW = 26,
    parameter int IW = 2
) (
    input  logic [N-1:0]         valid,
    input  logic [N-1:0][AW-1:0] tags,
    input  logic [AW-1:0]        key,
    output logic [N-1:0]         hit_vec,
    output logic                 any_hit,
    output logic [IW-1:0]        hit_idx
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hit_vec[g] = valid[g] && (tags[g] == key);
    end

    assign any_hit = |hit_vec;

    always_comb begin
        hit_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (hit_vec[i]) hit_idx = IW'(i);
        end
    end
endmodule

// File: rtl/vb_lru.sv
module vb_lru #(
    parameter int N  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch,
    input  logic [IW-1:0] touch_idx,
    output logic [IW-1:0] oldest_idx
);
    logic [N-1:0][IW-1:0] rank;
    logic [N-1:0]         is_new;
    logic [N-1:0]         is_old;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) rank[i] <= IW'(i);
        end else if (touch) begin
            for (int i = 0; i < N; i++) begin
                if (IW'(i) == touch_idx)
                    rank[i] <= '0;
                else if (rank[i] < rank[touch_idx])
                    rank[i] <= rank[i] + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_flag
        assign is_new[g] = (rank[g] == '0);
        assign is_old[g] = (rank[g] == IW'(N - 1));
    end

    always_comb begin
        oldest_idx = '0;
        for (int i = 0; i < N; i++) begin
            if (is_old[i]) oldest_idx = IW'(i);
        end
    end

    // R7: recency order is a permutation, so one newest and one oldest exist
    assert_rank_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_new) == 1);
    assert_rank_oldest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1);
    assert_touch_newest_R7: assert property (@(posedge clk) disable iff (!rst_n)
        touch |=> is_new[$past(touch_idx)]);
endmodule

// File: rtl/victim_buffer.sv
module victim_buffer
    import vb_pkg::*;
#(
    parameter int ENTRIES = 4,
    parameter int AW      = 26,
    parameter int DW      = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prb_valid,
    output logic          prb_ready,
    input  logic [AW-1:0] prb_addr,
    input  logic          dsp_valid,
    input  logic [AW-1:0] dsp_addr,
    input  logic          dsp_dirty,
    input  logic [DW-1:0] dsp_data,
    output logic          lk_done,
    output logic          lk_hit,
    output logic [DW-1:0] lk_data,
    output logic          lk_dirty,
    output logic          fill_valid,
    output logic [DW-1:0] fill_data,
    output logic          mem_req_valid,
    input  logic          mem_req_ready,
    output logic [AW-1:0] mem_req_addr,
    input  logic          mem_rsp_valid,
    input  logic [DW-1:0] mem_rsp_data,
    output logic          wb_valid,
    input  logic          wb_ready,
    output logic [AW-1:0] wb_addr,
    output logic [DW-1:0] wb_data
);
    localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    vb_state_e state, state_nx;

    logic [ENTRIES-1:0]         ent_v;
    logic [ENTRIES-1:0]         ent_dirty;
    logic [ENTRIES-1:0][AW-1:0] ent_a;
    logic [ENTRIES-1:0][DW-1:0] ent_data;

    logic [AW-1:0] req_q;
    logic          dsp_v_q;
    logic [AW-1:0] dsp_a_q;
    logic          dsp_dt_q;
    logic [DW-1:0] dsp_dat_q;
    logic [IW-1:0] vsel_q;
    logic [DW-1:0] fill_q;

    logic [ENTRIES-1:0] hit_vec;
    logic               any_hit;
    logic [IW-1:0]      hit_idx;
    logic [IW-1:0]      oldest_idx;
    logic [IW-1:0]      vsel;
    logic               need_wb;
    logic               wr_en;
    logic [IW-1:0]      wr_idx;
    logic               touch;

    vb_match #(.N(ENTRIES), .AW(AW), .IW(IW)) u_match (
        .valid   (ent_v),
        .tags    (ent_a),
        .key     (req_q),
        .hit_vec (hit_vec),
        .any_hit (any_hit),
        .hit_idx (hit_idx)
    );

    vb_lru #(.N(ENTRIES), .IW(IW)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch      (touch),
        .touch_idx  (wr_idx),
        .oldest_idx (oldest_idx)
    );

    // slot for a new line: lowest free entry, else the oldest one
    always_comb begin
        vsel = oldest_idx;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!ent_v[i]) vsel = IW'(i);
        end
    end
    assign need_wb = ent_v[vsel] && ent_dirty[vsel];

    // entry write control
    always_comb begin
        wr_en  = 1'b0;
        wr_idx = vsel;
        if (state == S_LOOK) begin
            if (any_hit) begin
                wr_en  = 1'b1;
                wr_idx = hit_idx;
            end else if (dsp_v_q && !need_wb) begin
                wr_en  = 1'b1;
            end
        end else if (state == S_WBACK && wb_ready) begin
            wr_en  = 1'b1;
            wr_idx = vsel_q;
        end
    end
    assign touch = wr_en && dsp_v_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v     <= '0;
            ent_dirty <= '0;
            ent_a     <= '0;
            ent_data  <= '0;
        end else if (wr_en) begin
            ent_v[wr_idx]     <= dsp_v_q;
            ent_dirty[wr_idx] <= dsp_dt_q;
            ent_a[wr_idx]     <= dsp_a_q;
            ent_data[wr_idx]  <= dsp_dat_q;
        end
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q     <= '0;
            dsp_v_q   <= 1'b0;
            dsp_a_q   <= '0;
            dsp_dt_q  <= 1'b0;
            dsp_dat_q <= '0;
            vsel_q    <= '0;
            fill_q    <= '0;
        end else begin
            if (state == S_IDLE && prb_valid) begin
                req_q     <= prb_addr;
                dsp_v_q   <= dsp_valid;
                dsp_a_q   <= dsp_addr;
                dsp_dt_q  <= dsp_dirty;
                dsp_dat_q <= dsp_data;
            end
            if (state == S_LOOK) vsel_q <= vsel;
            if (state == S_WAIT && mem_rsp_valid) fill_q <= mem_rsp_data;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (prb_valid) state_nx = S_LOOK;
            S_LOOK: begin
                if (any_hit)                 state_nx = S_IDLE;
                else if (dsp_v_q && need_wb) state_nx = S_WBACK;
                else                         state_nx = S_FETCH;
            end
            S_WBACK: if (wb_ready)      state_nx = S_FETCH;
            S_FETCH: if (mem_req_ready) state_nx = S_WAIT;
            S_WAIT:  if (mem_rsp_valid) state_nx = S_FILL;
            S_FILL:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    // outputs
    always_comb begin
        prb_ready     = 1'b0;
        lk_done       = 1'b0;
        lk_hit        = 1'b0;
        lk_data       = '0;
        lk_dirty      = 1'b0;
        fill_valid    = 1'b0;
        fill_data     = '0;
        mem_req_valid = 1'b0;
        mem_req_addr  = '0;
        wb_valid      = 1'b0;
        wb_addr       = '0;
        wb_data       = '0;
        unique case (state)
            S_IDLE: prb_ready = 1'b1;
            S_LOOK: begin
                lk_done = 1'b1;
                lk_hit  = any_hit;
                if (any_hit) begin
                    lk_data  = ent_data[hit_idx];
                    lk_dirty = ent_dirty[hit_idx];
                end
            end
            S_WBACK: begin
                wb_valid = 1'b1;
                wb_addr  = ent_a[vsel_q];
                wb_data  = ent_data[vsel_q];
            end
            S_FETCH: begin
                mem_req_valid = 1'b1;
                mem_req_addr  = req_q;
            end
            S_WAIT: ;
            S_FILL: begin
                fill_valid = 1'b1;
                fill_data  = fill_q;
            end
            default: ;
        endcase
    end

    // assertions
    assert_probe_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        prb_valid && prb_ready |=> lk_done);
    assert_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done |-> !prb_ready);
    assert_match_unique_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_vec));
    assert_hit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        lk_done && lk_hit |=> prb_ready && !mem_req_valid && !wb_valid);
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));
    assert_fill_follows_R5: assert property (@(posedge clk) disable iff (!rst_n)
        state == S_WAIT && mem_rsp_valid |=> fill_valid);
    assert_wb_then_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && wb_ready |=> mem_req_valid);
    assert_wb_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_addr));
endmodule

// File: tb/victim_buffer_tb.sv
`timescale 1ns/1ps
module victim_buffer_tb;
    localparam int N  = 4;
    localparam int AW = 26;
    localparam int DW = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          prb_valid = 1'b0;
    logic          prb_ready;
    logic [AW-1:0] prb_addr = '0;
    logic          dsp_valid = 1'b0;
    logic [AW-1:0] dsp_addr = '0;
    logic          dsp_dirty = 1'b0;
    logic [DW-1:0] dsp_data = '0;
    logic          lk_done, lk_hit, lk_dirty;
    logic [DW-1:0] lk_data;
    logic          fill_valid;
    logic [DW-1:0] fill_data;
    logic          mem_req_valid;
    logic          mem_req_ready = 1'b1;
    logic [AW-1:0] mem_req_addr;
    logic          mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic          wb_valid;
    logic          wb_ready = 1'b1;
    logic [AW-1:0] wb_addr;
    logic [DW-1:0] wb_data;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    victim_buffer #(.ENTRIES(N), .AW(AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .prb_valid(prb_valid), .prb_ready(prb_ready), .prb_addr(prb_addr),
        .dsp_valid(dsp_valid), .dsp_addr(dsp_addr), .dsp_dirty(dsp_dirty), .dsp_data(dsp_data),
        .lk_done(lk_done), .lk_hit(lk_hit), .lk_data(lk_data), .lk_dirty(lk_dirty),
        .fill_valid(fill_valid), .fill_data(fill_data),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
    );

    // reference model: recency queue, front is newest
    typedef struct {
        logic [AW-1:0] a;
        logic          d;
        logic [DW-1:0] dat;
    } line_t;
    line_t model_q[$];

    function automatic logic [DW-1:0] mem_line(input logic [AW-1:0] a);
        return 64'(a) * 64'h9E37_79B1 + 64'h1234;
    endfunction

    function automatic logic [DW-1:0] dsp_line(input logic [AW-1:0] a);
        return ~(64'(a) * 64'h0001_0003) ^ 64'h00FF_00FF_0000_0000;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic probe(input logic [AW-1:0] a, input bit dv,
                         input logic [AW-1:0] da, input bit dd);
        int     idx = -1;
        bit     exp_hit, exp_wb;
        line_t  hl, old, nl;
        exp_wb = 1'b0;
        nl.a = da; nl.d = dd; nl.dat = dsp_line(da);
        foreach (model_q[i]) if (model_q[i].a == a) idx = i;
        exp_hit = (idx >= 0);
        if (exp_hit) begin
            hl = model_q[idx];
            model_q.delete(idx);
            if (dv) model_q.push_front(nl);
        end else if (dv) begin
            if (model_q.size() == N) begin
                old = model_q.pop_back();
                exp_wb = old.d;
            end
            model_q.push_front(nl);
        end

        @(negedge clk);
        check(prb_ready == 1'b1, "R2", "ready before probe", 64'(prb_ready), 64'd1);
        prb_valid = 1'b1; prb_addr = a;
        dsp_valid = dv; dsp_addr = da; dsp_dirty = dd; dsp_data = dsp_line(da);
        @(negedge clk);
        prb_valid = 1'b0; dsp_valid = 1'b0;
        check(lk_done == 1'b1 && prb_ready == 1'b0, "R2", "lookup one cycle later",
              {lk_done, prb_ready}, 64'b10);
        check(lk_hit == exp_hit, exp_hit ? "R3" : "R5", "hit flag", 64'(lk_hit), 64'(exp_hit));
        if (exp_hit) begin
            check(lk_data == hl.dat && lk_dirty == hl.d, "R3", "hit line",
                  lk_data, hl.dat);
            @(negedge clk);
            check(prb_ready && !mem_req_valid && !wb_valid, "R4", "no traffic after hit",
                  {prb_ready, mem_req_valid, wb_valid}, 64'b100);
        end else begin
            @(negedge clk);
            if (exp_wb) begin
                check(wb_valid && wb_addr == old.a && wb_data == old.dat, "R7",
                      "write-back of oldest dirty", 64'(wb_addr), 64'(old.a));
                @(negedge clk);
            end else begin
                check(!wb_valid, "R8", "no write-back", 64'(wb_valid), 64'd0);
            end
            check(mem_req_valid && mem_req_addr == a, "R5", "next-level request",
                  64'(mem_req_addr), 64'(a));
            @(negedge clk);
            mem_rsp_valid = 1'b1; mem_rsp_data = mem_line(a);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            check(fill_valid && fill_data == mem_line(a), "R5", "fill data",
                  fill_data, mem_line(a));
            @(negedge clk);
            check(prb_ready, "R2", "idle after fill", 64'(prb_ready), 64'd1);
        end
    endtask

    localparam logic [AW-1:0] X = 26'h0000_040;
    localparam logic [AW-1:0] Y = 26'h0010_040;

    initial begin
        repeat (3) @(negedge clk);
        check(prb_ready && !lk_done && !fill_valid && !mem_req_valid && !wb_valid, "R1",
              "reset outputs", {prb_ready, lk_done, fill_valid, mem_req_valid, wb_valid},
              64'b10000);
        rst_n = 1'b1;
        // R1: empty after reset, first probe misses
        probe(26'h0000_111, 1'b0, '0, 1'b0);
        // R10 ping-pong between X and Y; R6 insert into free slot
        probe(X, 1'b0, '0, 1'b0);
        probe(Y, 1'b1, X, 1'b1);
        for (int k = 0; k < 4; k++) begin
            probe(X, 1'b1, Y, 1'b0);   // R4 swap
            probe(Y, 1'b1, X, 1'b1);   // R10 alternation hits
        end
        // R9 hit without displaced line frees the entry
        probe(X, 1'b0, '0, 1'b0);
        probe(X, 1'b0, '0, 1'b0);
        // R7/R8 overflow: fill with mixed dirty bits then push past capacity
        for (int k = 0; k < 9; k++) begin
            probe(26'h0200_000 + 26'(k), 1'b1, 26'h0300_000 + 26'(k), k[0]);
        end
        probe(26'h0300_008, 1'b1, 26'h0300_020, 1'b1);  // R3 hit on newest
        probe(26'h0300_000, 1'b1, 26'h0300_021, 1'b0);  // R7 discarded earlier: miss
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule